// File: doc/BRIEF.md
# Ternary-Masked Content-Addressable Entry Array

The block holds a small set of wide entries, by default 16 entries of 128 bits. Each entry carries two state flags, skip and empty. A compare command matches a comparand against every eligible entry in one clock. The result is held in a register: a match flag, the lowest-numbered matching entry, and, at all times, the lowest-numbered free entry together with a full indication.

A three-bit partition code splits each entry into two fields. The compared field is always tested. The stored-only field sits at the low end or the high end of the entry, in whole 32-bit segments. It is written and read back like the rest of the entry but never takes part in a compare. A per-bit compare mask can exclude further bits.

Reads, writes and flag updates reach one entry. That entry is picked directly by number, by an internal address register, by the next free entry, or by the last highest-priority match. Writes can be bit-masked, so selected bits of the entry are left as they were.

Top module: `tcam_array`

## Requirements
- R1: After reset every entry holds zero data with skip=0 and empty=1. After reset match_o=0, match_addr_o=0, free_addr_o=0, full_o=0 and rd_valid_o=0.
- R2: An automatic compare (cmd_i=1) considers only valid entries, meaning entries with skip=0 and empty=0.
- R3: A forced compare (cmd_i=2) considers only entries whose {skip,empty} equals cond_i, where cond_i[1] is skip and cond_i[0] is empty.
- R4: A comparand bit whose cmp_mask_i bit is 1 takes no part in the compare.
- R5: Partition code part_i: bits [1:0] give n, the number of 32-bit segments that are stored-only, limited to 3. Bit 2 places those segments at the most-significant end when 1, and at the least-significant end when 0. Stored-only bits never affect a match.
- R6: Compare results appear on the clock after the compare command and are held until the next compare. match_o is 1 when any entry matched. match_addr_o is the lowest-numbered matching entry, or 0 when none matched.
- R7: free_addr_o is the lowest-numbered entry with empty=1, or 0 when there is none. full_o is 1 exactly when no entry has empty=1. Both follow the flags on the clock after a flag change.
- R8: addr_src_i selects the entry for read, write and flag commands: 0 is addr_i, 1 is the address register, 2 is the next free entry, 3 is the held match address. Command 6 loads addr_i into the address register.
- R9: A write (cmd_i=3) updates the data bits whose wmask_i bit is 0 and keeps the bits whose wmask_i bit is 1. Only a write through source 2 changes a flag: it clears empty of that entry.
- R10: A command through source 2 while full_o=1, or through source 3 while match_o=0, has no effect. It writes no data or flags, and it gives no read pulse.
- R11: A read (cmd_i=4) gives the whole entry on rdata_o and its {skip,empty} on rflags_o on the next clock, with a one-clock pulse on rd_valid_o. Both output values are then held.
- R12: A flag command (cmd_i=5) sets {skip,empty} of the selected entry to flags_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command: 0 idle, 1 auto compare, 2 forced compare, 3 write, 4 read, 5 set flags, 6 load address register |
| addr_src_i | input | 2 | Entry selection source |
| addr_i | input | 4 | Direct entry number / address register load value |
| wdata_i | input | 128 | Write data |
| wmask_i | input | 128 | Write mask, 1 keeps the stored bit |
| flags_i | input | 2 | {skip,empty} for the flag command |
| comparand_i | input | 128 | Compare key |
| cmp_mask_i | input | 128 | Compare mask, 1 excludes the bit |
| cond_i | input | 2 | {skip,empty} condition for forced compare |
| part_i | input | 3 | Partition code |
| match_o | output | 1 | Last compare found a match |
| match_addr_o | output | 4 | Lowest matching entry of last compare |
| free_addr_o | output | 4 | Lowest empty entry |
| full_o | output | 1 | No entry is empty |
| rdata_o | output | 128 | Read data |
| rflags_o | output | 2 | {skip,empty} of the entry read |
| rd_valid_o | output | 1 | One-clock pulse after a read |

## Verification
The assertions assume that cmd_i carries one of the seven defined codes and that addr_i is in range during every clocked cycle after reset. They also assume that a write's selected entry number does not change between the command edge and the check. The bench issues at most one command per cycle, drives only defined codes, and changes inputs only on the falling edge, so every command sees stable operands. Entry contents are kept distinct apart from one deliberate duplicate, so each priority result has exactly one expected answer.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_AUTO  = 3'd1,
    CMD_FORCE = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_READ  = 3'd4,
    CMD_FLAGS = 3'd5,
    CMD_AREG  = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    SRC_DIRECT = 2'd0,
    SRC_AREG   = 2'd1,
    SRC_FREE   = 2'd2,
    SRC_MATCH  = 2'd3
  } src_e;
endpackage

// File: rtl/tcam_prio.sv
module tcam_prio #(
  parameter int N  = 16,
  parameter int AW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [AW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = AW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/tcam_store.sv
module tcam_store #(
  parameter int N  = 16,
  parameter int W  = 128,
  parameter int AW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_i,
  input  logic                clr_empty_i,
  input  logic                fe_i,
  input  logic [AW-1:0]       idx_i,
  input  logic [W-1:0]        wdata_i,
  input  logic [W-1:0]        wmask_i,
  input  logic [1:0]          flags_i,
  output logic [N-1:0][W-1:0] data_o,
  output logic [N-1:0]        skip_o,
  output logic [N-1:0]        empty_o
);
  logic [N-1:0][W-1:0] data_q;
  logic [N-1:0]        skip_q;
  logic [N-1:0]        empty_q;

  function automatic logic [W-1:0] merge_bits(input logic [W-1:0] old_v,
                                              input logic [W-1:0] new_v,
                                              input logic [W-1:0] keep);
    return (old_v & keep) | (new_v & ~keep);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      skip_q  <= '0;
      empty_q <= '1;
    end else begin
      if (we_i) begin
        data_q[idx_i] <= merge_bits(data_q[idx_i], wdata_i, wmask_i);
        if (clr_empty_i) empty_q[idx_i] <= 1'b0;
      end
      if (fe_i) begin
        skip_q[idx_i]  <= flags_i[1];
        empty_q[idx_i] <= flags_i[0];
      end
    end
  end

  assign data_o  = data_q;
  assign skip_o  = skip_q;
  assign empty_o = empty_q;

  // R9
  keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> ((data_q[$past(idx_i)] & $past(wmask_i)) == ($past(data_q[idx_i]) & $past(wmask_i))));

  // R9
  free_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && clr_empty_i) |=> !empty_q[$past(idx_i)]);

  // R12
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_i |=> ({skip_q[$past(idx_i)], empty_q[$past(idx_i)]} == $past(flags_i)));
endmodule

// File: rtl/tcam_match.sv
module tcam_match #(
  parameter int N  = 16,
  parameter int W  = 128,
  parameter int AW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmp_en_i,
  input  logic                forced_i,
  input  logic [1:0]          cond_i,
  input  logic [W-1:0]        key_i,
  input  logic [W-1:0]        care_i,
  input  logic [N-1:0][W-1:0] data_i,
  input  logic [N-1:0]        skip_i,
  input  logic [N-1:0]        empty_i,
  output logic                match_o,
  output logic [AW-1:0]       match_addr_o,
  output logic [N-1:0]        hit_o
);
  logic [N-1:0] elig_w;
  logic [N-1:0] hit_w;
  logic [N-1:0] hit_q;

  function automatic logic bits_agree(input logic [W-1:0] a, input logic [W-1:0] b,
                                      input logic [W-1:0] care);
    return ((a ^ b) & care) == '0;
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign elig_w[g] = forced_i ? ({skip_i[g], empty_i[g]} == cond_i)
                                : (!skip_i[g] && !empty_i[g]);
    assign hit_w[g]  = elig_w[g] && bits_agree(data_i[g], key_i, care_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hit_q <= '0;
    else if (cmp_en_i) hit_q <= hit_w;
  end

  tcam_prio #(.N(N), .AW(AW)) u_prio (
    .req_i (hit_q),
    .any_o (match_o),
    .idx_o (match_addr_o)
  );

  assign hit_o = hit_q;

  // R6
  match_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> hit_q[match_addr_o]);

  // R6
  lowest_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> ((hit_q & ((N'(1) << match_addr_o) - N'(1))) == '0));

  // R6
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en_i |=> $stable(hit_q));
endmodule

// File: rtl/tcam_array.sv
module tcam_array #(
  parameter int N     = 16,
  parameter int W     = 128,
  parameter int SEG_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cmd_i,
  input  logic [1:0]           addr_src_i,
  input  logic [$clog2(N)-1:0] addr_i,
  input  logic [W-1:0]         wdata_i,
  input  logic [W-1:0]         wmask_i,
  input  logic [1:0]           flags_i,
  input  logic [W-1:0]         comparand_i,
  input  logic [W-1:0]         cmp_mask_i,
  input  logic [1:0]           cond_i,
  input  logic [2:0]           part_i,
  output logic                 match_o,
  output logic [$clog2(N)-1:0] match_addr_o,
  output logic [$clog2(N)-1:0] free_addr_o,
  output logic                 full_o,
  output logic [W-1:0]         rdata_o,
  output logic [1:0]           rflags_o,
  output logic                 rd_valid_o
);
  import tcam_pkg::*;

  localparam int AW   = $clog2(N);
  localparam int SEGS = W / SEG_W;

  cmd_e cmd_w;
  src_e src_w;
  assign cmd_w = cmd_e'(cmd_i);
  assign src_w = src_e'(addr_src_i);

  logic [N-1:0][W-1:0] data_w;
  logic [N-1:0]        skip_w;
  logic [N-1:0]        empty_w;
  logic [N-1:0]        hit_w;
  logic                any_free_w;
  logic [AW-1:0]       areg_q;
  logic [AW-1:0]       sel_idx_w;
  logic                sel_ok_w;
  logic                wr_fire_w;
  logic                fl_fire_w;
  logic                rd_fire_w;
  logic                cmp_fire_w;
  logic [W-1:0]        care_w;
  logic [W-1:0]        rdata_q;
  logic [1:0]          rflags_q;
  logic                rd_valid_q;

  // Compared-field mask from the partition code: 1 marks a compared bit.
  function automatic logic [W-1:0] cam_field(input logic [2:0] code);
    int n;
    logic [W-1:0] m;
    n = int'(code[1:0]);
    if (n > SEGS - 1) n = SEGS - 1;
    m = '0;
    for (int s = 0; s < SEGS; s++) begin
      if (code[2] ? (s < SEGS - n) : (s >= n))
        m[s*SEG_W +: SEG_W] = '1;
    end
    return m;
  endfunction

  assign care_w = cam_field(part_i) & ~cmp_mask_i;

  always_comb begin
    sel_idx_w = addr_i;
    sel_ok_w  = 1'b1;
    case (src_w)
      SRC_DIRECT: begin sel_idx_w = addr_i;       sel_ok_w = 1'b1;        end
      SRC_AREG:   begin sel_idx_w = areg_q;       sel_ok_w = 1'b1;        end
      SRC_FREE:   begin sel_idx_w = free_addr_o;  sel_ok_w = any_free_w;  end
      SRC_MATCH:  begin sel_idx_w = match_addr_o; sel_ok_w = match_o;     end
      default:    begin sel_idx_w = addr_i;       sel_ok_w = 1'b1;        end
    endcase
  end

  assign wr_fire_w  = (cmd_w == CMD_WRITE) && sel_ok_w;
  assign fl_fire_w  = (cmd_w == CMD_FLAGS) && sel_ok_w;
  assign rd_fire_w  = (cmd_w == CMD_READ)  && sel_ok_w;
  assign cmp_fire_w = (cmd_w == CMD_AUTO) || (cmd_w == CMD_FORCE);

  tcam_store #(.N(N), .W(W), .AW(AW)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_i        (wr_fire_w),
    .clr_empty_i (src_w == SRC_FREE),
    .fe_i        (fl_fire_w),
    .idx_i       (sel_idx_w),
    .wdata_i     (wdata_i),
    .wmask_i     (wmask_i),
    .flags_i     (flags_i),
    .data_o      (data_w),
    .skip_o      (skip_w),
    .empty_o     (empty_w)
  );

  tcam_match #(.N(N), .W(W), .AW(AW)) u_match (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmp_en_i     (cmp_fire_w),
    .forced_i     (cmd_w == CMD_FORCE),
    .cond_i       (cond_i),
    .key_i        (comparand_i),
    .care_i       (care_w),
    .data_i       (data_w),
    .skip_i       (skip_w),
    .empty_i      (empty_w),
    .match_o      (match_o),
    .match_addr_o (match_addr_o),
    .hit_o        (hit_w)
  );

  tcam_prio #(.N(N), .AW(AW)) u_free (
    .req_i (empty_w),
    .any_o (any_free_w),
    .idx_o (free_addr_o)
  );

  assign full_o = !any_free_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      areg_q     <= '0;
      rdata_q    <= '0;
      rflags_q   <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      if (cmd_w == CMD_AREG) areg_q <= addr_i;
      rd_valid_q <= rd_fire_w;
      if (rd_fire_w) begin
        rdata_q  <= data_w[sel_idx_w];
        rflags_q <= {skip_w[sel_idx_w], empty_w[sel_idx_w]};
      end
    end
  end

  assign rdata_o    = rdata_q;
  assign rflags_o   = rflags_q;
  assign rd_valid_o = rd_valid_q;

  // R7
  free_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full_o |-> empty_w[free_addr_o]);

  // R11
  read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w == CMD_READ && sel_ok_w) |=> (rd_valid_o && rdata_o == $past(data_w[sel_idx_w])));

  // R10
  blocked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w == CMD_READ && src_w == SRC_FREE && full_o) |=> !rd_valid_o);

  // R10
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w == CMD_WRITE && src_w == SRC_MATCH && !match_o) |=> $stable(data_w));
endmodule

// File: tb/tcam_array_bench.sv
module tcam_array_bench;
  localparam int N = 16;
  localparam int W = 128;

  logic clk = 0;
  logic rst_n = 0;
  logic [2:0]   cmd_i = 0;
  logic [1:0]   addr_src_i = 0;
  logic [3:0]   addr_i = 0;
  logic [W-1:0] wdata_i = 0, wmask_i = 0, comparand_i = 0, cmp_mask_i = 0;
  logic [1:0]   flags_i = 0, cond_i = 0;
  logic [2:0]   part_i = 0;
  logic         match_o, full_o, rd_valid_o;
  logic [3:0]   match_addr_o, free_addr_o;
  logic [W-1:0] rdata_o;
  logic [1:0]   rflags_o;

  always #5 clk = ~clk;

  tcam_array u_tcam_array (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .addr_src_i(addr_src_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .wmask_i(wmask_i), .flags_i(flags_i), .comparand_i(comparand_i),
    .cmp_mask_i(cmp_mask_i), .cond_i(cond_i), .part_i(part_i), .match_o(match_o),
    .match_addr_o(match_addr_o), .free_addr_o(free_addr_o), .full_o(full_o),
    .rdata_o(rdata_o), .rflags_o(rflags_o), .rd_valid_o(rd_valid_o)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  logic [W-1:0] m_data [N];
  logic         m_skip [N];
  logic         m_empty[N];
  logic         m_match;
  logic [3:0]   m_maddr;
  logic [3:0]   m_areg;

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int m_free();
    for (int i = 0; i < N; i++) if (m_empty[i]) return i;
    return -1;
  endfunction

  function automatic bit bit_compared(int b, logic [2:0] code);
    int seg, n;
    seg = b / 32;
    n = code[1:0];
    if (n == 4) n = 3;
    if (code[2]) return seg + n <= 3;
    return seg >= n;
  endfunction

  task automatic model_cmd(logic [2:0] c);
    int idx; bit ok;
    case (addr_src_i)
      2'd0: begin idx = addr_i; ok = 1; end
      2'd1: begin idx = m_areg; ok = 1; end
      2'd2: begin idx = m_free(); ok = (idx >= 0); if (!ok) idx = 0; end
      default: begin idx = m_maddr; ok = m_match; end
    endcase
    if (c == 3'd1 || c == 3'd2) begin
      m_match = 0; m_maddr = 0;
      for (int e = N - 1; e >= 0; e--) begin
        bit elig, eq;
        elig = (c == 3'd2) ? (m_skip[e] == cond_i[1] && m_empty[e] == cond_i[0])
                           : (!m_skip[e] && !m_empty[e]);
        eq = 1;
        for (int b = 0; b < W; b++)
          if (!cmp_mask_i[b] && bit_compared(b, part_i) && m_data[e][b] != comparand_i[b]) eq = 0;
        if (elig && eq) begin m_match = 1; m_maddr = 4'(e); end
      end
    end else if (c == 3'd3 && ok) begin
      for (int b = 0; b < W; b++) if (!wmask_i[b]) m_data[idx][b] = wdata_i[b];
      if (addr_src_i == 2'd2) m_empty[idx] = 0;
    end else if (c == 3'd5 && ok) begin
      m_skip[idx] = flags_i[1]; m_empty[idx] = flags_i[0];
    end else if (c == 3'd6) m_areg = addr_i;
  endtask

  // apply one command at a falling edge; return at the falling edge after its capture
  task automatic step(logic [2:0] c);
    @(negedge clk);
    cmd_i = c;
    model_cmd(c);
    @(negedge clk);
    cmd_i = 0;
  endtask

  task automatic read_chk(string tag, logic [3:0] idx);
    addr_src_i = 0; addr_i = idx;
    step(3'd4);
    chk({tag, " rd_valid"}, W'(rd_valid_o), W'(1));
    chk({tag, " rdata"}, rdata_o, m_data[idx]);
    chk({tag, " rflags"}, W'(rflags_o), W'({m_skip[idx], m_empty[idx]}));
  endtask

  task automatic cmp_chk(string tag, logic [2:0] c);
    step(c);
    chk({tag, " match"}, W'(match_o), W'(m_match));
    chk({tag, " addr"}, W'(match_addr_o), W'(m_maddr));
  endtask

  function automatic logic [W-1:0] pat(int i);
    logic [W-1:0] v;
    for (int w = 0; w < 4; w++) v[w*32 +: 32] = (32'h1357_9BDF * (w + 1)) ^ (32'h0101_0101 * i);
    return v;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_data[i] = 0; m_skip[i] = 0; m_empty[i] = 1; end
    m_match = 0; m_maddr = 0; m_areg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 match", W'(match_o), 0);
    chk("R1 maddr", W'(match_addr_o), 0);
    chk("R1 free", W'(free_addr_o), 0);
    chk("R1 full", W'(full_o), 0);
    chk("R1 rd_valid", W'(rd_valid_o), 0);
    read_chk("R1 entry", 4'd5);

    // R10 match-source read with no match: no pulse
    addr_src_i = 3; step(3'd4);
    chk("R10 read via empty match", W'(rd_valid_o), 0);

    // R7 R9 fill through next-free source
    wmask_i = 0;
    for (int i = 0; i < N; i++) begin
      chk("R7 free addr", W'(free_addr_o), W'(i));
      chk("R7 not full", W'(full_o), 0);
      addr_src_i = 2; wdata_i = pat(i); step(3'd3);
    end
    chk("R7 full", W'(full_o), 1);
    chk("R7 free when full", W'(free_addr_o), 0);
    addr_src_i = 2; wdata_i = '1; step(3'd3);
    read_chk("R10 write when full", 4'd0);
    addr_src_i = 2; step(3'd4);
    chk("R10 read when full", W'(rd_valid_o), 0);
    for (int i = 0; i < N; i++) read_chk("R9 fill", 4'(i));

    // R12 flag states
    for (int i = 0; i < N; i += 5) begin addr_src_i = 0; addr_i = 4'(i); flags_i = 2'b10; step(3'd5); end
    addr_i = 7;  flags_i = 2'b01; step(3'd5);
    addr_i = 11; flags_i = 2'b01; step(3'd5);
    addr_i = 13; flags_i = 2'b11; step(3'd5);
    read_chk("R12 flags", 4'd13);
    read_chk("R12 flags", 4'd10);
    chk("R7 free after flags", W'(free_addr_o), 7);
    chk("R7 full after flags", W'(full_o), 0);

    // R9 masked direct write: duplicate entry 2 into entry 9 in two halves
    addr_src_i = 0; addr_i = 9; wdata_i = pat(2);
    wmask_i = {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}; step(3'd3);
    read_chk("R9 masked upper", 4'd9);
    wmask_i = {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}; step(3'd3);
    read_chk("R9 masked lower", 4'd9);
    wmask_i = {32{4'b1010}}; wdata_i = '0; addr_i = 6; step(3'd3);
    read_chk("R9 alternate mask", 4'd6);
    wmask_i = 0;

    // R2 R6 auto compare against every entry's contents
    part_i = 0; cmp_mask_i = 0;
    for (int k = 0; k < N; k++) begin
      comparand_i = m_data[k];
      cmp_chk("R2 R6 auto", 3'd1);
    end
    // R6 priority between duplicate entries 2 and 9
    comparand_i = m_data[2];
    cmp_chk("R6 priority", 3'd1);
    chk("R6 lowest", W'(match_addr_o), 2);
    step(3'd0);
    chk("R6 held", W'(match_addr_o), 2);

    // R3 forced compares over every condition and entry
    for (int cnd = 0; cnd < 4; cnd++) begin
      cond_i = 2'(cnd);
      for (int k = 0; k < N; k += 3) begin
        comparand_i = m_data[k];
        cmp_chk("R3 forced", 3'd2);
      end
    end

    // R4 mask sweep: differing bits masked out
    for (int s = 0; s < 4; s++) begin
      comparand_i = m_data[4] ^ (W'(32'hF0) << (s * 32));
      cmp_mask_i = 0;
      cmp_chk("R4 unmasked", 3'd1);
      cmp_mask_i = W'(32'hF0) << (s * 32);
      cmp_chk("R4 masked", 3'd1);
    end
    cmp_mask_i = 0;

    // R5 partition sweep
    for (int p = 0; p < 8; p++) begin
      part_i = 3'(p);
      for (int s = 0; s < 4; s++) begin
        comparand_i = m_data[3] ^ (W'(1) << (s * 32 + 1));
        cmp_chk("R5 partition", 3'd1);
      end
    end
    part_i = 0;

    // R8 sources: address register, match, free
    addr_i = 12; step(3'd6);
    addr_src_i = 1; wdata_i = pat(40); step(3'd3);
    read_chk("R8 areg write", 4'd12);
    comparand_i = m_data[8]; cmp_chk("R8 setup", 3'd1);
    addr_src_i = 3; wdata_i = pat(41); step(3'd3);
    read_chk("R8 match write", 4'd8);
    addr_src_i = 2; wdata_i = pat(42); step(3'd3);
    read_chk("R8 free write", 4'd7);
    chk("R8 free moves", W'(free_addr_o), 11);
    addr_src_i = 1; step(3'd4);
    chk("R11 areg read", rdata_o, m_data[12]);
    step(3'd0);
    chk("R11 pulse ends", W'(rd_valid_o), 0);
    chk("R11 data held", rdata_o, m_data[12]);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule